// File: doc/BRIEF.md
# Interrupt Polarity Normalizing Gateway

This block sits between a set of external interrupt pins and a downstream interrupt controller that accepts only rising-edge or active-high requests. Each pin has its own 3-bit sense code and an enable bit. The block synchronizes every pin, then turns active-low levels, falling edges and both-edge activity into either an active-high level or a one-cycle high pulse. Each output is gated by the pin's enable bit.

Software programs the block through a small 32-bit register port with a write strobe and a combinational read. Enable bits are packed 32 to a word. Each pin's sense code sits in a word of its own. The block does no prioritization, no acknowledgement and no remapping of pin numbers: output line p always carries pin p.

Top module: `irq_polarity_gw`

## Requirements
- R1: After reset, every enable bit reads 0, every sense field reads 3'b100 (level active-high), and all outputs are low.
- R2: The enable bit of pin p is bit p%32 of the word at byte address 0x10 + 4*(p/32). A word is written whole. Bits for pins at or above NUM_PINS (default 126) read as zero.
- R3: The sense field of pin p is bits [2:0] of the word at byte address 0x110 + 4*p. A write stores only bits [2:0]. A read returns the 3 bits zero-extended to 32.
- R4: Reads of any other address return zero, including sense slots at or above pin NUM_PINS. Writes there change no stored state.
- R5: Sense 3'b100 (level active-high): the output follows the input. A change that is set up before clock edge k shows at the output after edge k+2.
- R6: Sense 3'b000 (level active-low): the output is the inverse of the input, with the same latency as R5.
- R7: Sense 3'b110 (rising edge): each rising transition of the input gives exactly one output cycle high, and a falling transition gives none.
- R8: Sense 3'b010 (falling edge): each falling transition gives exactly one output cycle high, and a rising transition gives none.
- R9: Sense 3'b111 (both edges): each transition in either direction gives exactly one output cycle high.
- R10: Sense codes 3'b001, 3'b011 and 3'b101 keep the output low.
- R11: When a pin's enable bit is clear, its output is low from the clock edge after the enable is cleared.
- R12: Pins are independent: activity on one pin never changes another pin's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_i | input | NUM_PINS | Raw external interrupt pins |
| irq_o | output | NUM_PINS | Normalized interrupt requests to the downstream controller |

## Verification
A table drives one pin through a single transition, upward and downward, under every valid sense code and under each invalid code. It counts the output's high cycles and records its final level over a fixed window. A count of 6 against 2 separates a level that turned on from one that turned off. A count of 1 with a low final level marks a single-cycle pulse, and a count of 0 shows a transition that this sense code ignores. A second, enabled pin stays quiet through the whole table to show that pins do not affect each other. Directed tests then cover exact latency, the highest pin's address mapping, masking of bits above the pin count, sense field width, unmapped reads and the enable gate.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;
  localparam int unsigned EN_BASE  = 'h10;
  localparam int unsigned CFG_BASE = 'h110;

  localparam logic [2:0] SENSE_LVL_LO = 3'b000;
  localparam logic [2:0] SENSE_FALL   = 3'b010;
  localparam logic [2:0] SENSE_LVL_HI = 3'b100;
  localparam logic [2:0] SENSE_RISE   = 3'b110;
  localparam logic [2:0] SENSE_BOTH   = 3'b111;
endpackage

// File: rtl/irq_gw_regs.sv
module irq_gw_regs
  import irq_gw_pkg::*;
#(
  parameter int unsigned NUM_PINS = 126,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output logic [NUM_PINS-1:0]          en_o,
  output logic [NUM_PINS-1:0][2:0]     cfg_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [ADDR_W-1:0] EnAddr  = ADDR_W'(EN_BASE + 4 * (p / 32));
    localparam logic [ADDR_W-1:0] CfgAddr = ADDR_W'(CFG_BASE + 4 * p);
    localparam int unsigned       Bit     = p % 32;

    logic       en_r;
    logic [2:0] cfg_r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_r  <= 1'b0;
        cfg_r <= SENSE_LVL_HI;
      end else if (we_i) begin
        if (addr_i == EnAddr)  en_r  <= wdata_i[Bit];
        if (addr_i == CfgAddr) cfg_r <= wdata_i[2:0];
      end
    end

    assign en_o[p]  = en_r;
    assign cfg_o[p] = cfg_r;
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_i == ADDR_W'(EN_BASE + 4 * (p / 32))) rdata_o[p[4:0]] = en_o[p];
      if (addr_i == ADDR_W'(CFG_BASE + 4 * p))       rdata_o = {29'b0, cfg_o[p]};
    end
  end

endmodule

// File: rtl/irq_gw_sync.sv
module irq_gw_sync #(
  parameter int unsigned WIDTH = 126
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

endmodule

// File: rtl/irq_gw_lane.sv
module irq_gw_lane
  import irq_gw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic       en_i,
  input  logic [2:0] cfg_i,
  output logic       irq_o
);

  logic prev_q;
  logic req_d;

  always_comb begin
    unique case (cfg_i)
      SENSE_LVL_LO: req_d = ~sync_i;
      SENSE_LVL_HI: req_d = sync_i;
      SENSE_RISE:   req_d = sync_i & ~prev_q;
      SENSE_FALL:   req_d = ~sync_i & prev_q;
      SENSE_BOTH:   req_d = sync_i ^ prev_q;
      default:      req_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      irq_o  <= en_i & req_d;
    end
  end

endmodule

// File: rtl/irq_polarity_gw.sv
module irq_polarity_gw
  import irq_gw_pkg::*;
#(
  parameter int unsigned NUM_PINS = 126,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic [NUM_PINS-1:0] irq_i,
  output logic [NUM_PINS-1:0] irq_o
);

  logic [NUM_PINS-1:0]      en_q;
  logic [NUM_PINS-1:0][2:0] cfg_q;
  logic [NUM_PINS-1:0]      irq_sync;

  irq_gw_regs #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W)
  ) regs_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .en_o   (en_q),
    .cfg_o  (cfg_q)
  );

  irq_gw_sync #(
    .WIDTH(NUM_PINS)
  ) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (irq_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
    irq_gw_lane lane_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sync_i(irq_sync[p]),
      .en_i  (en_q[p]),
      .cfg_i (cfg_q[p]),
      .irq_o (irq_o[p])
    );
  end

endmodule

// File: rtl/irq_polarity_gw_chk.sv
module irq_polarity_gw_chk
  import irq_gw_pkg::*;
#(
  parameter int unsigned NUM_PINS = 126
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_PINS-1:0]      irq_o,
  input logic [NUM_PINS-1:0]      en_q,
  input logic [NUM_PINS-1:0][2:0] cfg_q
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (irq_o == '0);
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assert_rise_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[p] && cfg_q[p] == SENSE_RISE) |=> !irq_o[p]);

    assert_fall_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[p] && cfg_q[p] == SENSE_FALL) |=> !irq_o[p]);

    assert_bad_code_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[p] == 3'b001 || cfg_q[p] == 3'b011 || cfg_q[p] == 3'b101) |=> !irq_o[p]);

    assert_disabled_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q[p] |=> !irq_o[p]);
  end

endmodule

bind irq_polarity_gw irq_polarity_gw_chk #(
  .NUM_PINS(NUM_PINS)
) chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .irq_o (irq_o),
  .en_q  (en_q),
  .cfg_q (cfg_q)
);

// File: tb/irq_polarity_gw_tb_top.sv
`timescale 1ns / 1ps
module irq_polarity_gw_tb_top;
  localparam int unsigned NP = 126;
  localparam int unsigned AW = 12;
  localparam int unsigned NV = 13;
  localparam int unsigned PIN = 5;
  localparam int unsigned BUDDY = 6;

  // {sense[2:0], start level, end level, high cycles[3:0], final level}
  localparam logic [9:0] VEC [NV] = '{
    {3'b000, 1'b1, 1'b0, 4'd6, 1'b1},
    {3'b000, 1'b0, 1'b1, 4'd2, 1'b0},
    {3'b100, 1'b0, 1'b1, 4'd6, 1'b1},
    {3'b100, 1'b1, 1'b0, 4'd2, 1'b0},
    {3'b110, 1'b0, 1'b1, 4'd1, 1'b0},
    {3'b110, 1'b1, 1'b0, 4'd0, 1'b0},
    {3'b010, 1'b1, 1'b0, 4'd1, 1'b0},
    {3'b010, 1'b0, 1'b1, 4'd0, 1'b0},
    {3'b111, 1'b0, 1'b1, 4'd1, 1'b0},
    {3'b111, 1'b1, 1'b0, 4'd1, 1'b0},
    {3'b001, 1'b0, 1'b1, 4'd0, 1'b0},
    {3'b011, 1'b1, 1'b0, 4'd0, 1'b0},
    {3'b101, 1'b0, 1'b1, 4'd0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] irq_in = '0;
  logic [NP-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_polarity_gw #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_i      (irq_in),
    .irq_o      (irq_out)
  );

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'b000:  return "R6";
      3'b100:  return "R5";
      3'b110:  return "R7";
      3'b010:  return "R8";
      3'b111:  return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : main
    logic [31:0] r;
    int highs;
    int buddy_hits;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int w = 0; w < 4; w++) begin
      rd('h10 + 4 * w, r); chk(r, 0, "R1 enable word");
    end
    rd('h110, r);           chk(r, 4, "R1 sense pin0");
    rd('h110 + 4 * 125, r); chk(r, 4, "R1 sense pin125");
    chk(32'(irq_out != '0), 0, "R1 outputs low");

    // R2 top word masked to valid pins
    wr('h1C, 32'hFFFF_FFFF);
    rd('h1C, r); chk(r, 32'h3FFF_FFFF, "R2 top word mask");
    wr('h1C, 32'h0);

    // R3 sense field width
    wr('h110 + 4 * 7, 32'hFFFF_FFFF);
    rd('h110 + 4 * 7, r); chk(r, 7, "R3 sense zero-extend");
    wr('h110 + 4 * 7, 32'h4);

    // R4 unmapped addresses
    wr('h308, 32'hFFFF_FFFF);
    rd('h000, r); chk(r, 0, "R4 addr 0x000");
    rd('h00C, r); chk(r, 0, "R4 addr 0x00C");
    rd('h020, r); chk(r, 0, "R4 addr 0x020");
    rd('h10C, r); chk(r, 0, "R4 addr 0x10C");
    rd('h308, r); chk(r, 0, "R4 pin126 slot");
    rd('h304, r); chk(r, 4, "R4 pin125 untouched");

    // R2/R12 highest pin mapping
    wr('h1C, 32'h2000_0000);
    irq_in[125] = 1'b1;
    idle(5);
    chk(32'(irq_out[125]), 1, "R2 pin125 enabled via word3 bit29");
    chk(32'(irq_out[124:0] != '0), 0, "R12 other pins quiet");
    irq_in[125] = 1'b0;
    wr('h1C, 32'h0);

    // R5 exact latency
    wr('h10, (32'h1 << PIN) | (32'h1 << BUDDY));
    idle(5);
    irq_in[PIN] = 1'b1;
    @(negedge clk); chk(32'(irq_out[PIN]), 0, "R5 latency edge k");
    @(negedge clk); chk(32'(irq_out[PIN]), 0, "R5 latency edge k+1");
    @(negedge clk); chk(32'(irq_out[PIN]), 1, "R5 latency edge k+2");

    // R11 enable gate
    wr('h10, 32'h1 << BUDDY);
    chk(32'(irq_out[PIN]), 1, "R11 before gate edge");
    @(negedge clk); chk(32'(irq_out[PIN]), 0, "R11 gated low");
    idle(3);        chk(32'(irq_out[PIN]), 0, "R11 stays low");
    wr('h10, (32'h1 << PIN) | (32'h1 << BUDDY));
    @(negedge clk); chk(32'(irq_out[PIN]), 1, "R11 re-enabled");

    // table of sense codes and transitions
    for (int v = 0; v < NV; v++) begin
      logic [2:0] s;
      s = VEC[v][9:7];
      wr('h110 + 4 * PIN, {29'b0, s});
      irq_in[PIN] = VEC[v][6];
      idle(8);
      highs = 0;
      buddy_hits = 0;
      irq_in[PIN] = VEC[v][5];
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (irq_out[PIN]) highs++;
        if (irq_out[BUDDY]) buddy_hits++;
      end
      chk(32'(highs), 32'(VEC[v][4:1]), {tag_of(s), " high cycles"});
      chk(32'(irq_out[PIN]), 32'(VEC[v][0]), {tag_of(s), " final level"});
      chk(32'(buddy_hits), 0, "R12 neighbour pin quiet");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule